// File: doc/BRIEF.md
# Presettable Up/Down Decade or Binary Counter Chain

This block is a synchronous reversible counter built from 4-bit digit stages. Each digit counts either over 0..9 (decade) or over 0..15 (binary), chosen by a parameter. All stages share one clock and advance together on its rising edge. The direction line chooses up or down counting, and an active-low count enable gates counting.

An active-low parallel load presets every digit from a data bus at once, with no clock needed. A terminal flag marks the count edge in the current direction: all digits at their maximum when counting up, or all at zero when counting down. An active-low ripple output pulses during the low half of the clock when the chain is enabled and at that edge. Digits pass carry and borrow to the next digit by enabling it only when every lower digit is at its terminal value.

A single-digit instance behaves as one stand-alone counter stage. A wider instance forms a multi-digit counter whose combined value appears on one bus, least significant digit in bits 3:0.

Top module: `updn_chain`

## Requirements
- R1: The count changes only on a rising clock edge and only when cnt_en_n is low. With cnt_en_n high, the count holds.
- R2: dn low selects counting up and dn high selects counting down.
- R3: While load_n is low, count equals load_val at once, whatever the clock level. Load takes priority over reset and counting at the same edge, and counting resumes from the loaded value after load_n rises.
- R4: With DECADE=1, a digit wraps from 9 to 0 going up and from 0 to 9 going down. With DECADE=0, it wraps from 15 to 0 going up and from 0 to 15 going down.
- R5: With DECADE=1, a digit holding 10..15 moves to 0 when counting up, or to 9 when counting down, on the next enabled edge. It passes no carry or borrow.
- R6: max_min is high whenever every digit is at its maximum with dn low, or every digit is zero with dn high. This holds whatever the state of cnt_en_n.
- R7: rco_n is low only while clk is low, cnt_en_n is low and the R6 condition holds. It is high at all other times.
- R8: Digit i occupies count[4i+3:4i]. A digit above digit 0 steps only on an edge where cnt_en_n is low and every lower digit is at its terminal value for the current direction.
- R9: With rst high at a rising edge and load_n high, count becomes 0.
- R10: Changes on cnt_en_n or dn between rising edges leave the stored count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en_n | input | 1 | Count enable, active low |
| dn | input | 1 | Direction: 0 up, 1 down |
| load_n | input | 1 | Asynchronous parallel load, active low |
| load_val | input | 4*NUM_DIGITS | Preset value, one 4-bit field per digit |
| count | output | 4*NUM_DIGITS | Combined count, digit 0 in bits 3:0 |
| max_min | output | 1 | Whole chain at its terminal value for dn |
| rco_n | output | 1 | Ripple output, low in clock low phase at terminal while enabled |

## Verification
Two pairs of functions can collide at a single rising edge. A preset can arrive while counting is enabled, and a preset can arrive while reset is high. The bench provokes both by holding load_n low across an edge with cnt_en_n low, and then again with rst high. It judges the result by requiring the loaded value both during the load and after its release. Flag timing is also judged against the clock phase: max_min and rco_n are sampled in the low half of each cycle, and rco_n is sampled in the high half as well.

// File: rtl/updn_pkg.sv
`timescale 1ns/1ps
package updn_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Largest legal digit value for the selected range.
    function automatic digit_t digit_top(input bit decade);
        return decade ? digit_t'(9) : digit_t'(15);
    endfunction

    // Next digit value; out-of-range decade values recover to a legal one.
    function automatic digit_t digit_step(input digit_t v, input dir_e dir, input bit decade);
        digit_t top;
        top = digit_top(decade);
        if (dir == DIR_UP) begin
            return (v >= top) ? digit_t'(0) : digit_t'(v + digit_t'(1));
        end
        if (v == digit_t'(0) || v > top) begin
            return top;
        end
        return digit_t'(v - digit_t'(1));
    endfunction

    // Terminal value for the current direction.
    function automatic logic at_terminal(input digit_t v, input dir_e dir, input bit decade);
        return (dir == DIR_UP) ? (v == digit_top(decade)) : (v == digit_t'(0));
    endfunction

endpackage

// File: rtl/updn_digit.sv
`timescale 1ns/1ps
module updn_digit
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   en_n,
    input  logic   dn,
    input  logic   load_n,
    input  digit_t din,
    output digit_t q,
    output logic   term,
    output logic   carry_n
);

    digit_t q_r;
    dir_e   dir;

    assign dir = dir_e'(dn);

    // Preset is asynchronous and dominant; reset and counting are synchronous.
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            q_r <= din;
        end else if (rst) begin
            q_r <= '0;
        end else if (!en_n) begin
            q_r <= digit_step(q_r, dir, DECADE);
        end
    end

    // During preset the data bus is visible at once, whatever the clock level.
    assign q       = load_n ? q_r : din;
    assign term    = at_terminal(q, dir, DECADE);
    assign carry_n = ~(term & ~en_n);

endmodule

// File: rtl/updn_rco.sv
`timescale 1ns/1ps
module updn_rco (
    input  logic clk,
    input  logic carry_n,
    output logic rco_n
);

    // The pulse is allowed only in the low half of the clock.
    assign rco_n = carry_n | clk;

endmodule

// File: rtl/updn_chain.sv
`timescale 1ns/1ps
module updn_chain
    import updn_pkg::*;
#(
    parameter int NUM_DIGITS = 2,
    parameter bit DECADE     = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cnt_en_n,
    input  logic                          dn,
    input  logic                          load_n,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] load_val,
    output logic [NUM_DIGITS*DIGIT_W-1:0] count,
    output logic                          max_min,
    output logic                          rco_n
);

    localparam int LAST = NUM_DIGITS;

    // en_chain_n[i] enables digit i; en_chain_n[i+1] is digit i's ungated carry.
    logic [LAST:0]         en_chain_n;
    logic [NUM_DIGITS-1:0] dig_term;

    assign en_chain_n[0] = cnt_en_n;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        updn_digit #(.DECADE(DECADE)) u_dig (
            .clk     (clk),
            .rst     (rst),
            .en_n    (en_chain_n[g]),
            .dn      (dn),
            .load_n  (load_n),
            .din     (load_val[g*DIGIT_W +: DIGIT_W]),
            .q       (count[g*DIGIT_W +: DIGIT_W]),
            .term    (dig_term[g]),
            .carry_n (en_chain_n[g+1])
        );
    end

    assign max_min = &dig_term;

    updn_rco u_rco (
        .clk     (clk),
        .carry_n (en_chain_n[LAST]),
        .rco_n   (rco_n)
    );

endmodule

// File: rtl/updn_chain_chk.sv
`timescale 1ns/1ps
module updn_chain_chk #(
    parameter int NUM_DIGITS = 2,
    parameter bit DECADE     = 1'b1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cnt_en_n,
    input logic                    dn,
    input logic                    load_n,
    input logic [NUM_DIGITS*4-1:0] count,
    input logic                    max_min,
    input logic                    rco_n,
    input logic [NUM_DIGITS-1:0]   dig_term
);

    localparam logic [3:0] TOPV = DECADE ? 4'd9 : 4'd15;

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (load_n && cnt_en_n) |=> (!load_n || $stable(count)));

    p_up_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && !dn && count[3:0] == TOPV) |=> (!load_n || count[3:0] == 4'd0));

    p_down_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && dn && count[3:0] == 4'd0) |=> (!load_n || count[3:0] == TOPV));

    if (DECADE) begin : g_dec
        p_illegal_up_r5: assert property (@(posedge clk) disable iff (rst)
            (load_n && !cnt_en_n && !dn && count[3:0] > 4'd9) |=> (!load_n || count[3:0] == 4'd0));
    end

    // Sampled values at a rising edge belong to the low half of the clock.
    p_rco_low_r7: assert property (@(posedge clk) disable iff (rst)
        rco_n == !(max_min && !cnt_en_n));

    p_rco_high_r7: assert property (@(negedge clk) disable iff (rst)
        rco_n);

    if (NUM_DIGITS > 1) begin : g_chain
        p_carry_r8: assert property (@(posedge clk) disable iff (rst)
            (load_n && !(dig_term[0] && !cnt_en_n)) |=> (!load_n || $stable(count[NUM_DIGITS*4-1:4])));
    end

endmodule

bind updn_chain updn_chain_chk #(.NUM_DIGITS(NUM_DIGITS), .DECADE(DECADE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_en_n (cnt_en_n),
    .dn       (dn),
    .load_n   (load_n),
    .count    (count),
    .max_min  (max_min),
    .rco_n    (rco_n),
    .dig_term (dig_term)
);

// File: tb/updn_chain_test.sv
`timescale 1ns/1ps
module updn_chain_test;

    localparam logic [3:0] TOP = 4'd9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en_n = 1'b1;
    logic       dn = 1'b0;
    logic       load_n = 1'b1;
    logic [7:0] load_val = 8'h00;
    logic [7:0] count;
    logic       max_min;
    logic       rco_n;
    logic [3:0] bin_count;
    logic       bin_mm;
    logic       bin_rco;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] exp_q[$];
    logic [3:0] mdl[2];

    always #4 clk = ~clk;

    updn_chain #(.NUM_DIGITS(2), .DECADE(1'b1)) uut (
        .clk(clk), .rst(rst), .cnt_en_n(cnt_en_n), .dn(dn), .load_n(load_n),
        .load_val(load_val), .count(count), .max_min(max_min), .rco_n(rco_n)
    );

    updn_chain #(.NUM_DIGITS(1), .DECADE(1'b0)) uut_bin (
        .clk(clk), .rst(rst), .cnt_en_n(cnt_en_n), .dn(dn), .load_n(load_n),
        .load_val(load_val[3:0]), .count(bin_count), .max_min(bin_mm), .rco_n(bin_rco)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic mterm(input logic [3:0] v, input logic d);
        return d ? (v == 4'd0) : (v == TOP);
    endfunction

    function automatic logic [3:0] mstep(input logic [3:0] v, input logic d);
        if (!d) return (v < TOP) ? v + 4'd1 : 4'd0;
        if (v > TOP) return TOP;
        return (v == 4'd0) ? TOP : v - 4'd1;
    endfunction

    // Driver: one clock of counting with the given controls.
    task automatic cycle(input logic en_n_v, input logic dn_v);
        logic go;
        logic all_t;
        @(negedge clk);
        cnt_en_n = en_n_v;
        dn = dn_v;
        #1;
        all_t = mterm(mdl[0], dn_v) && mterm(mdl[1], dn_v);
        check(max_min === all_t, "R6 max_min", max_min, all_t);
        check(rco_n === !(all_t && !en_n_v), "R7 rco_n low phase", rco_n, !(all_t && !en_n_v));
        go = !en_n_v;
        for (int i = 0; i < 2; i++) begin
            logic t;
            t = mterm(mdl[i], dn_v);
            if (go) mdl[i] = mstep(mdl[i], dn_v);
            go = go && t;
        end
        exp_q.push_back({mdl[1], mdl[0]});
    endtask

    task automatic do_load(input logic [7:0] v, input logic en_n_v, input logic with_rst);
        @(negedge clk);
        load_val = v;
        load_n = 1'b0;
        cnt_en_n = en_n_v;
        rst = with_rst;
        #1;
        check(count === v, "R3 preset in low phase", count, v);
        mdl[0] = v[3:0];
        mdl[1] = v[7:4];
        exp_q.push_back(v);
        @(posedge clk);
        #2;
        check(count === v, "R3 preset across edge", count, v);
        load_n = 1'b1;
        rst = 1'b0;
        cnt_en_n = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cnt_en_n = 1'b0;
        mdl[0] = 4'd0;
        mdl[1] = 4'd0;
        exp_q.push_back(8'h00);
        @(posedge clk);
        #2;
        rst = 1'b0;
        cnt_en_n = 1'b1;
        check(count === 8'h00, "R9 reset while enabled", count, 8'h00);
    endtask

    // R10: control changes between edges do not alter the count.
    task automatic glitch_ctrl();
        logic [7:0] held;
        @(posedge clk);
        #2;
        held = count;
        cnt_en_n = 1'b0;
        dn = ~dn;
        #1;
        check(count === held, "R10 enable change mid cycle", count, held);
        dn = ~dn;
        #1;
        check(count === held, "R10 direction change mid cycle", count, held);
        cnt_en_n = 1'b1;
    endtask

    task automatic bin_check(input logic [3:0] e, input string tag);
        @(posedge clk);
        #2;
        check(bin_count === e, tag, bin_count, e);
    endtask

    // Monitor: scoreboard pop after each rising edge, plus high-phase ripple check.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            check(rco_n === 1'b1, "R7 rco_n high phase", rco_n, 1'b1);
            if (exp_q.size() != 0) begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(count === e, "R1 R2 R4 R5 R8 count", count, e);
            end
        end
    end

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        mdl[0] = 4'd0;
        mdl[1] = 4'd0;
        repeat (3) @(posedge clk);
        #2;
        check(count === 8'h00, "R9 reset value", count, 8'h00);
        check(max_min === 1'b0, "R6 reset flag", max_min, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // Preset 7, up through the digit wrap, inhibit, then down again.
        do_load(8'h07, 1'b1, 1'b0);
        repeat (5) cycle(1'b0, 1'b0);
        cycle(1'b1, 1'b0);
        cycle(1'b1, 1'b1);
        glitch_ctrl();
        repeat (5) cycle(1'b0, 1'b1);

        // Multi-digit carry and borrow (R8).
        do_load(8'h98, 1'b1, 1'b0);
        repeat (3) cycle(1'b0, 1'b0);
        do_load(8'h01, 1'b1, 1'b0);
        repeat (3) cycle(1'b0, 1'b1);
        do_load(8'h99, 1'b1, 1'b0);
        cycle(1'b1, 1'b0);
        cycle(1'b1, 1'b1);

        // Out-of-range decade digits (R5).
        do_load(8'h0C, 1'b1, 1'b0);
        cycle(1'b0, 1'b0);
        do_load(8'h3D, 1'b1, 1'b0);
        cycle(1'b0, 1'b1);
        do_load(8'hF9, 1'b1, 1'b0);
        cycle(1'b0, 1'b0);

        // Preset colliding with counting, then with reset (R3).
        do_load(8'h45, 1'b0, 1'b0);
        cycle(1'b0, 1'b0);
        do_load(8'h62, 1'b0, 1'b1);
        cycle(1'b0, 1'b1);
        do_reset();
        cycle(1'b0, 1'b1);

        // Binary range on the single-digit instance (R4, R6).
        do_load(8'h0F, 1'b1, 1'b0);
        dn = 1'b0;
        #1;
        check(bin_mm === 1'b1, "R6 binary max flag", bin_mm, 1'b1);
        cycle(1'b0, 1'b0);
        bin_check(4'h0, "R4 binary wrap up");
        cycle(1'b0, 1'b1);
        bin_check(4'hF, "R4 binary wrap down");

        // Random traffic against the model.
        for (int k = 0; k < 500; k++) begin
            if ($urandom_range(0, 9) == 0)
                do_load(8'($urandom), 1'($urandom), 1'b0);
            else
                cycle($urandom_range(0, 3) == 0, 1'($urandom));
        end

        repeat (3) @(posedge clk);
        #2;
        check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule